// File: doc/BRIEF.md
# Reference Clock Monitor and Priority Selector

This block watches four candidate frequency references and three one-pulse-per-second (PPS) candidates, all sampled in the system clock domain. Each reference is judged by counting its rising edges across a fixed gate window of system clocks. A window with no edges marks the source absent. A count outside a tolerance band around the expected value marks it off frequency. From these results a selector picks the active reference. It runs either automatically by fixed priority, with a hold-off before it moves back up to a better source, or manually through a select field.

Per-source fault events collect in a sticky pending register with write-one-to-clear semantics. A mask turns chosen bits into the interrupt line. A separate selector picks the PPS source by its own priority. It treats a PPS input as alive while its last rising edge lies within a timeout.

Top module: `refclk_guard`

## Requirements
- R1: After reset, ref_sel and pps_sel are 0, ref_valid and pps_valid are 0, and ref_absent, ref_offfreq, irq_pend and irq are all 0.
- R2: A source whose sampled input shows no rising edge during a gate window of GATE system clocks has its ref_absent bit set when that window is evaluated, and its ref_offfreq bit clear.
- R3: A source with a nonzero edge count farther than TOL from every expected count has its ref_offfreq bit set. Sources 0, 1 and 3 each have one expected count. Source 2, the external input, accepts any of three counts, for 20, 10 and 5 MHz.
- R4: In automatic mode the selected index is the healthy source with the highest priority. The encoding is 0 = site link A, 1 = site link B, 2 = external input, 3 = oven oscillator, and 0 has the highest priority. A source is healthy when it is neither absent nor off frequency.
- R5: In automatic mode, a move to a source of higher priority than the current one happens only when that source has been healthy for at least hold_win consecutive windows. A move away from a selected source that has turned faulty happens at the next evaluation.
- R6: With auto_mode low, ref_sel follows man_sel, and ref_valid shows whether that source is healthy.
- R7: In automatic mode, when no source is healthy ref_valid is 0 and ref_sel keeps its previous value.
- R8: irq_pend is sticky. Bit i (0 to 3) is set by an absent result for source i, and bit 4+i is set by an off-frequency result for source i, at each evaluated window.
- R9: A cycle with irq_clr_we high clears the irq_pend bits where irq_clr_data is 1. Bits where irq_clr_data is 0 are left unchanged.
- R10: irq is high exactly when some irq_pend bit is set whose irq_en bit is 1. Pending bits that are masked do not raise irq.
- R11: In automatic PPS mode, pps_sel is the alive PPS source with the highest priority. The encoding is 0 = site-link PPS, 1 = PPS recovered from the external reference, 2 = dedicated external PPS, and 0 has the highest priority. A source is alive while fewer than PPS_TMO cycles have passed since its last rising edge.
- R12: When no PPS source is alive in automatic mode, pps_valid is 0 and pps_sel holds its previous value. In manual mode, pps_sel follows pps_man, and pps_valid shows whether that source is alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 4 | Candidate reference clocks, index = priority |
| pps_in | input | 3 | Candidate PPS inputs, index = priority |
| auto_mode | input | 1 | 1 = automatic reference selection |
| man_sel | input | 2 | Manual reference index |
| hold_win | input | STK_W | Healthy windows required before moving up |
| pps_auto | input | 1 | 1 = automatic PPS selection |
| pps_man | input | 2 | Manual PPS index |
| irq_en | input | 8 | Interrupt enable per pending bit |
| irq_clr_we | input | 1 | Write strobe for clearing pending bits |
| irq_clr_data | input | 8 | Ones clear the matching pending bits |
| ref_sel | output | 2 | Selected reference index |
| ref_valid | output | 1 | Selected reference is healthy |
| ref_absent | output | 4 | Per-source absent status |
| ref_offfreq | output | 4 | Per-source off-frequency status |
| irq_pend | output | 8 | Sticky pending faults (absent low nibble, off-frequency high nibble) |
| irq | output | 1 | Interrupt line |
| pps_sel | output | 2 | Selected PPS index |
| pps_valid | output | 1 | Selected PPS source is alive |

## Verification
A window ends on the cycle the gate counter reaches GATE-1. The status bits appear one cycle later. ref_sel, ref_valid and irq_pend change two cycles after the window ends, and irq changes three cycles after. PPS liveness follows each input edge after three synchronizer and edge stages. The bench applies each pattern on a falling edge and then waits four whole windows, or several timeouts for PPS, before it samples on a falling edge. Every transition window has then been overwritten by settled ones. Register writes are checked four cycles after the strobe.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int NREF  = 4;
  localparam int NPPS  = 3;
  localparam int IDX_W = 2;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/rcm_freq_meter.sv
module rcm_freq_meter #(
  parameter int GATE      = 64,
  parameter int TOL       = 1,
  parameter int EXPS [3]  = '{16, 16, 16},
  parameter int STK_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             win_end,
  output logic             absent,
  output logic             offfreq,
  output logic [STK_W-1:0] streak
);
  localparam int CNT_W = $clog2(GATE + 1);

  logic [2:0]       sy;
  logic             rise;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [2:0]       match;
  logic             zero;

  always_ff @(posedge clk) begin
    if (rst) sy <= '0;
    else     sy <= {sy[1:0], ref_in};
  end
  assign rise    = sy[1] & ~sy[2];
  assign cnt_nxt = cnt + CNT_W'(rise);
  assign zero    = (cnt_nxt == '0);

  for (genvar k = 0; k < 3; k++) begin : g_band
    assign match[k] = (int'(cnt_nxt) + TOL >= EXPS[k]) &&
                      (int'(cnt_nxt) <= EXPS[k] + TOL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      absent  <= 1'b0;
      offfreq <= 1'b0;
      streak  <= '0;
    end else if (win_end) begin
      cnt     <= '0;
      absent  <= zero;
      offfreq <= ~zero & ~|match;
      if (zero || !(|match))  streak <= '0;
      else if (~&streak)      streak <= streak + 1'b1;
    end else begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rcm_ref_select.sv
module rcm_ref_select import rcm_pkg::*; (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [NREF-1:0] healthy,
  input  logic [NREF-1:0] qual,
  input  logic            auto_mode,
  input  idx_t            man_sel,
  output idx_t            sel,
  output logic            valid
);
  idx_t best_h, best_q, nxt;
  logic any_h, any_q;

  always_comb begin
    best_h = '0; best_q = '0; any_h = 1'b0; any_q = 1'b0;
    for (int i = NREF - 1; i >= 0; i--) begin
      if (healthy[i]) begin best_h = idx_t'(i); any_h = 1'b1; end
      if (qual[i])    begin best_q = idx_t'(i); any_q = 1'b1; end
    end
    nxt = sel;
    if (!auto_mode)              nxt = man_sel;
    else if (healthy[sel]) begin
      if (any_q && best_q < sel) nxt = best_q;
    end else if (any_h)          nxt = best_h;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      valid <= 1'b0;
    end else if (upd) begin
      sel   <= nxt;
      valid <= healthy[nxt];
    end
  end
endmodule

// File: rtl/rcm_pps_select.sv
module rcm_pps_select import rcm_pkg::*; #(
  parameter int PPS_TMO = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPPS-1:0] pps_in,
  input  logic            pps_auto,
  input  idx_t            pps_man,
  output idx_t            sel,
  output logic            valid
);
  localparam int CW = $clog2(PPS_TMO + 1);

  logic [NPPS-1:0] alive;
  logic [3:0]      alive_x;
  idx_t            best, nxt;
  logic            any, nxt_vld;

  for (genvar i = 0; i < NPPS; i++) begin : g_src
    logic [2:0]    sy;
    logic [CW-1:0] age;
    always_ff @(posedge clk) begin
      if (rst) begin
        sy  <= '0;
        age <= CW'(PPS_TMO);
      end else begin
        sy <= {sy[1:0], pps_in[i]};
        if (sy[1] & ~sy[2])         age <= '0;
        else if (age != CW'(PPS_TMO)) age <= age + 1'b1;
      end
    end
    assign alive[i] = (age < CW'(PPS_TMO));
  end

  assign alive_x = 4'(alive);

  always_comb begin
    best = '0; any = 1'b0;
    for (int i = NPPS - 1; i >= 0; i--)
      if (alive[i]) begin best = idx_t'(i); any = 1'b1; end
    if (pps_auto) begin
      nxt     = any ? best : sel;
      nxt_vld = any;
    end else begin
      nxt     = pps_man;
      nxt_vld = alive_x[pps_man];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      valid <= 1'b0;
    end else begin
      sel   <= nxt;
      valid <= nxt_vld;
    end
  end
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard import rcm_pkg::*; #(
  parameter int GATE        = 64,
  parameter int TOL         = 1,
  parameter int EXP_LINK    = 16,
  parameter int EXP_EXT_HI  = 16,
  parameter int EXP_EXT_MID = 8,
  parameter int EXP_EXT_LO  = 4,
  parameter int EXP_OVEN    = 8,
  parameter int STK_W       = 3,
  parameter int PPS_TMO     = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREF-1:0]   ref_in,
  input  logic [NPPS-1:0]   pps_in,
  input  logic              auto_mode,
  input  logic [IDX_W-1:0]  man_sel,
  input  logic [STK_W-1:0]  hold_win,
  input  logic              pps_auto,
  input  logic [IDX_W-1:0]  pps_man,
  input  logic [2*NREF-1:0] irq_en,
  input  logic              irq_clr_we,
  input  logic [2*NREF-1:0] irq_clr_data,
  output logic [IDX_W-1:0]  ref_sel,
  output logic              ref_valid,
  output logic [NREF-1:0]   ref_absent,
  output logic [NREF-1:0]   ref_offfreq,
  output logic [2*NREF-1:0] irq_pend,
  output logic              irq,
  output logic [IDX_W-1:0]  pps_sel,
  output logic              pps_valid
);
  localparam int GW = $clog2(GATE);

  logic [GW-1:0]    gate_cnt;
  logic             win_end, upd;
  logic [NREF-1:0]  healthy, qual;
  logic [STK_W-1:0] streak [NREF];

  assign win_end = (gate_cnt == GW'(GATE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_cnt <= '0;
      upd      <= 1'b0;
    end else begin
      gate_cnt <= win_end ? '0 : gate_cnt + 1'b1;
      upd      <= win_end;
    end
  end

  for (genvar i = 0; i < NREF; i++) begin : g_meter
    localparam int E0 = (i < 2) ? EXP_LINK : (i == 2) ? EXP_EXT_HI  : EXP_OVEN;
    localparam int E1 = (i < 2) ? EXP_LINK : (i == 2) ? EXP_EXT_MID : EXP_OVEN;
    localparam int E2 = (i < 2) ? EXP_LINK : (i == 2) ? EXP_EXT_LO  : EXP_OVEN;
    rcm_freq_meter #(.GATE(GATE), .TOL(TOL), .EXPS('{E0, E1, E2}), .STK_W(STK_W)) u_meter (
      .clk(clk), .rst(rst), .ref_in(ref_in[i]), .win_end(win_end),
      .absent(ref_absent[i]), .offfreq(ref_offfreq[i]), .streak(streak[i])
    );
    assign healthy[i] = ~(ref_absent[i] | ref_offfreq[i]);
    assign qual[i]    = healthy[i] && (streak[i] >= hold_win);
  end

  rcm_ref_select u_sel (
    .clk(clk), .rst(rst), .upd(upd), .healthy(healthy), .qual(qual),
    .auto_mode(auto_mode), .man_sel(man_sel), .sel(ref_sel), .valid(ref_valid)
  );

  rcm_pps_select #(.PPS_TMO(PPS_TMO)) u_pps (
    .clk(clk), .rst(rst), .pps_in(pps_in), .pps_auto(pps_auto),
    .pps_man(pps_man), .sel(pps_sel), .valid(pps_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= '0;
      irq      <= 1'b0;
    end else begin
      irq_pend <= (irq_pend & ~(irq_clr_we ? irq_clr_data : '0)) |
                  (upd ? {ref_offfreq, ref_absent} : '0);
      irq      <= |(irq_pend & irq_en);
    end
  end
endmodule

// File: rtl/refclk_guard_chk.sv
module refclk_guard_chk import rcm_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              upd,
  input logic [IDX_W-1:0]  ref_sel,
  input logic              ref_valid,
  input logic [NREF-1:0]   ref_absent,
  input logic [NREF-1:0]   ref_offfreq,
  input logic [2*NREF-1:0] irq_pend,
  input logic              irq_clr_we,
  input logic [2*NREF-1:0] irq_clr_data,
  input logic [IDX_W-1:0]  pps_sel,
  input logic              pps_valid
);
  a_r6_valid_tracks_health: assert property (@(posedge clk) disable iff (rst)
    upd |=> (ref_valid == !(ref_absent[ref_sel] | ref_offfreq[ref_sel])));

  a_r3_absent_excludes_off: assert property (@(posedge clk) disable iff (rst)
    (ref_absent & ref_offfreq) == '0);

  a_r5_sel_moves_on_eval: assert property (@(posedge clk) disable iff (rst)
    !$past(upd) |-> $stable(ref_sel));

  a_r9_pend_falls_on_clear: assert property (@(posedge clk) disable iff (rst)
    (($past(irq_pend) & ~irq_pend &
      ~($past(irq_clr_we) ? $past(irq_clr_data) : '0)) == '0));

  a_r11_pps_sel_range: assert property (@(posedge clk) disable iff (rst)
    pps_valid |-> (int'(pps_sel) < NPPS));
endmodule

bind refclk_guard refclk_guard_chk u_chk (
  .clk(clk), .rst(rst), .upd(upd), .ref_sel(ref_sel), .ref_valid(ref_valid),
  .ref_absent(ref_absent), .ref_offfreq(ref_offfreq), .irq_pend(irq_pend),
  .irq_clr_we(irq_clr_we), .irq_clr_data(irq_clr_data),
  .pps_sel(pps_sel), .pps_valid(pps_valid)
);

// File: tb/refclk_guard_tb_top.sv
module refclk_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GATE       = 64;
  localparam int WAIT_WIN   = 4 * GATE;

  typedef struct packed {
    logic [3:0] hpa, hpb, hpe, hpo;
    logic       au;
    logic [1:0] man;
    logic [1:0] sel;
    logic       vld;
    logic [3:0] abs_m, off_m;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'd2, 4'd2, 4'd2, 4'd4, 1'b1, 2'd0, 2'd0, 1'b1, 4'b0000, 4'b0000},
    '{4'd0, 4'd2, 4'd2, 4'd4, 1'b1, 2'd0, 2'd1, 1'b1, 4'b0001, 4'b0000},
    '{4'd3, 4'd0, 4'd2, 4'd4, 1'b1, 2'd0, 2'd2, 1'b1, 4'b0010, 4'b0001},
    '{4'd0, 4'd0, 4'd4, 4'd4, 1'b1, 2'd0, 2'd2, 1'b1, 4'b0011, 4'b0000},
    '{4'd0, 4'd0, 4'd8, 4'd4, 1'b1, 2'd0, 2'd2, 1'b1, 4'b0011, 4'b0000},
    '{4'd0, 4'd0, 4'd3, 4'd4, 1'b1, 2'd0, 2'd3, 1'b1, 4'b0011, 4'b0100},
    '{4'd0, 4'd0, 4'd3, 4'd2, 1'b1, 2'd0, 2'd3, 1'b0, 4'b0011, 4'b1100},
    '{4'd2, 4'd2, 4'd2, 4'd4, 1'b0, 2'd2, 2'd2, 1'b1, 4'b0000, 4'b0000},
    '{4'd2, 4'd2, 4'd3, 4'd4, 1'b0, 2'd2, 2'd2, 1'b0, 4'b0000, 4'b0100},
    '{4'd2, 4'd2, 4'd2, 4'd4, 1'b1, 2'd0, 2'd0, 1'b1, 4'b0000, 4'b0000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ref_in = '0;
  logic [2:0] pps_in = '0;
  logic       auto_mode = 1'b1;
  logic [1:0] man_sel = '0;
  logic [2:0] hold_win = '0;
  logic       pps_auto = 1'b1;
  logic [1:0] pps_man = '0;
  logic [7:0] irq_en = '0;
  logic       irq_clr_we = 1'b0;
  logic [7:0] irq_clr_data = '0;
  logic [1:0] ref_sel, pps_sel;
  logic       ref_valid, irq, pps_valid;
  logic [3:0] ref_absent, ref_offfreq;
  logic [7:0] irq_pend;

  int hp [4] = '{0, 0, 0, 0};
  int pc [4] = '{0, 0, 0, 0};
  logic [2:0] pps_on = 3'b111;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  refclk_guard dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .pps_in(pps_in),
    .auto_mode(auto_mode), .man_sel(man_sel), .hold_win(hold_win),
    .pps_auto(pps_auto), .pps_man(pps_man), .irq_en(irq_en),
    .irq_clr_we(irq_clr_we), .irq_clr_data(irq_clr_data),
    .ref_sel(ref_sel), .ref_valid(ref_valid), .ref_absent(ref_absent),
    .ref_offfreq(ref_offfreq), .irq_pend(irq_pend), .irq(irq),
    .pps_sel(pps_sel), .pps_valid(pps_valid)
  );

  // reference waveforms: hp = half period in system clocks, 0 = stuck low
  initial begin
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (hp[i] == 0) ref_in[i] = 1'b0;
        else begin
          pc[i] = pc[i] + 1;
          if (pc[i] >= hp[i]) begin pc[i] = 0; ref_in[i] = ~ref_in[i]; end
        end
      end
    end
  end

  // PPS pulses: two cycles high every 100 cycles on enabled inputs
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph == 99) ? 0 : ph + 1;
      pps_in = (ph < 2) ? pps_on : 3'b000;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_pend(input logic [7:0] mask);
    irq_clr_we = 1'b1; irq_clr_data = mask;
    @(negedge clk);
    irq_clr_we = 1'b0; irq_clr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    // R1 reset state
    check("R1 ref_sel",   32'(ref_sel), 0);
    check("R1 ref_valid", 32'(ref_valid), 0);
    check("R1 status",    32'({ref_absent, ref_offfreq}), 0);
    check("R1 irq_pend",  32'(irq_pend), 0);
    check("R1 irq",       32'(irq), 0);
    check("R1 pps",       32'({pps_sel, pps_valid}), 0);

    // table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < 10; v++) begin
      hp[0] = int'(VEC[v].hpa); hp[1] = int'(VEC[v].hpb);
      hp[2] = int'(VEC[v].hpe); hp[3] = int'(VEC[v].hpo);
      auto_mode = VEC[v].au; man_sel = VEC[v].man;
      wait_cyc(WAIT_WIN);
      check("R4 R6 R7 ref_sel", 32'(ref_sel), 32'(VEC[v].sel));
      check("R6 R7 ref_valid",  32'(ref_valid), 32'(VEC[v].vld));
      check("R2 ref_absent",    32'(ref_absent), 32'(VEC[v].abs_m));
      check("R3 ref_offfreq",   32'(ref_offfreq), 32'(VEC[v].off_m));
    end

    // R5 hold-off before moving up
    hold_win = 3'd3;
    hp = '{2, 2, 2, 4};
    wait_cyc(WAIT_WIN);
    check("R5 start on A", 32'(ref_sel), 0);
    hp[0] = 0;
    wait_cyc(3 * GATE);
    check("R5 drop to B at once", 32'(ref_sel), 1);
    hp[0] = 2;
    wait_cyc(2 * GATE);
    check("R5 still B during hold", 32'(ref_sel), 1);
    wait_cyc(6 * GATE);
    check("R5 back to A after hold", 32'(ref_sel), 0);
    hold_win = '0;

    // R8 R9 R10 interrupt path
    irq_en = '0;
    wait_cyc(2 * GATE);
    clear_pend(8'hFF);
    wait_cyc(4);
    check("R9 cleared all", 32'(irq_pend), 0);
    check("R10 irq low", 32'(irq), 0);
    hp[1] = 0;
    wait_cyc(3 * GATE);
    check("R8 B absent pend", 32'(irq_pend[1:0]), 32'h2);
    check("R10 masked no irq", 32'(irq), 0);
    irq_en = 8'h02;
    wait_cyc(4);
    check("R10 enabled irq", 32'(irq), 1);
    clear_pend(8'h01);
    wait_cyc(4);
    check("R9 other bit kept", 32'(irq_pend[1]), 1);
    hp[0] = 3;
    wait_cyc(3 * GATE);
    check("R8 A off pend", 32'({irq_pend[4], irq_pend[0]}), 32'h2);
    hp[0] = 2; hp[1] = 2;
    wait_cyc(3 * GATE);
    clear_pend(8'hFF);
    wait_cyc(4);
    check("R9 clear after recovery", 32'(irq_pend), 0);
    check("R10 irq drops", 32'(irq), 0);

    // R11 R12 PPS selection
    pps_on = 3'b111;
    wait_cyc(600);
    check("R11 pps top", 32'({pps_sel, pps_valid}), 32'b001);
    pps_on = 3'b110;
    wait_cyc(400);
    check("R11 pps next", 32'({pps_sel, pps_valid}), 32'b011);
    pps_on = 3'b010;
    wait_cyc(400);
    check("R11 pps keeps 1", 32'({pps_sel, pps_valid}), 32'b011);
    pps_on = 3'b000;
    wait_cyc(400);
    check("R12 none alive hold", 32'({pps_sel, pps_valid}), 32'b010);
    pps_auto = 1'b0; pps_man = 2'd2;
    wait_cyc(4);
    check("R12 manual dead", 32'({pps_sel, pps_valid}), 32'b100);
    pps_on = 3'b100;
    wait_cyc(300);
    check("R12 manual alive", 32'({pps_sel, pps_valid}), 32'b101);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule